// File: doc/BRIEF.md
# Key-Steered Two-Phase Row Reader

This block controls reads from an array whose encrypted cells are built from two complementary storage devices. The ciphertext bit sets which device sits at low threshold. For a requested row, the reader decides which device of each cell gets the read bias, based on the key. It then walks the row through a small bank of sense amplifiers, one column group per cycle. The sensed bits are collected, merged, and returned as one plaintext row.

No XOR is applied after sensing. Decryption happens because the key steers the bias.

Keys come in three forms:
- **Per-row key bit.** One bias pattern covers the whole row, so one pass is enough.
- **Unencrypted rows.** These use a single-device bias and also take one pass.
- **Per-bit key vector.** The row shares one word line, so it takes two passes:
  - The first pass biases the upper device everywhere.
  - The second pass biases the lower device.
  - The first-pass bits are buffered and merged with the second-pass bits, bit by bit, under the key.

With the wrong key, every bit whose key is wrong comes back inverted. Bits whose key is right are still recovered.

Top module: `rdr_decrypt_reader`

## Requirements
- R1: After reset, `busy` and `data_valid` are 0, `arr_bias` is 0 (no bias) and `data_out` is all zero.
- R2: A request is accepted only when `busy` is 0. From the next cycle, `busy` stays 1 and `arr_row` holds the requested row until the result is delivered. A `req_valid` pulse seen while `busy` is 1 changes neither the bias sequence nor the result.
- R3: The bias codes on `arr_bias` are:

  | Code | Meaning |
  |------|---------|
  | 0 | none |
  | 1 | upper device (key 1) |
  | 2 | lower device (key 0) |
  | 3 | single device (unencrypted) |

  A read cycle never shows code 0.
- R4: The modes on `req_mode` are:

  | Code | Mode |
  |------|------|
  | 2'b00 | unencrypted |
  | 2'b01 | per-row key |
  | 2'b10 | per-bit key |
  | 2'b11 | reserved |

  In per-bit mode (2'b10), all GROUPS column groups are first read with code 1, then all GROUPS again with code 2. That is 2·GROUPS = 16 read cycles at the defaults.
- R5: In per-row mode (2'b01), there is a single pass of GROUPS cycles. It uses code 1 when `req_rowkey` is 1 and code 2 when it is 0. `req_key` has no effect in this mode.
- R6: In unencrypted mode (2'b00), and in reserved mode (2'b11), there is a single pass of GROUPS cycles with code 3. The result equals the sensed bits.
- R7: In each pass, `arr_grp` starts at 0 and rises by one per read cycle. Sense bit i in group g becomes row bit g·N_SA+i.
- R8: In per-bit mode, result bit b comes from the first pass where `req_key[b]`=1 and from the second pass where it is 0.
- R9: `data_valid` is high for exactly one cycle, two cycles after the last read cycle. `busy` is 0 in that cycle. `data_out` holds until the next result.
- R10: With the key used at write time, the result equals the stored plaintext. With any other key, the result equals plaintext XOR true key XOR applied key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_row | input | AW | Row to read |
| req_mode | input | 2 | Key mode (R4 codes) |
| req_key | input | ROW_W | Per-bit key vector |
| req_rowkey | input | 1 | Per-row key bit |
| busy | output | 1 | Read in progress |
| arr_row | output | AW | Row driven to the array |
| arr_grp | output | GW | Column group on the sense amplifiers |
| arr_bias | output | 2 | Bias pattern (R3 codes) |
| sa_bits | input | N_SA | Sense-amplifier results for the current group |
| data_out | output | ROW_W | Recovered plaintext row |
| data_valid | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a per-bit read where the first-pass buffer must win for some bits and the second-pass buffer for others. That only happens when the key vector mixes ones and zeros. The stimulus therefore writes ciphertext under a mixed true key and reads it back under four keys: the correct one, all zeros, an unrelated pattern, and uniform keys. The wrong keys expose exactly the bits each buffer supplies. A second hard case is a request arriving mid-read. The bench pulses `req_valid` with a different row and mode in the fourth read cycle, and confirms that the bias sequence and result are unchanged.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'b00,
        MODE_ROWKEY = 2'b01,
        MODE_BITKEY = 2'b10,
        MODE_RSVD   = 2'b11
    } key_mode_e;

    typedef enum logic [1:0] {
        BIAS_NONE   = 2'd0,
        BIAS_UPPER  = 2'd1,
        BIAS_LOWER  = 2'd2,
        BIAS_SINGLE = 2'd3
    } bias_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PH1,
        ST_PH2,
        ST_OUT
    } rd_state_e;

    // Bias applied during the first (or only) pass.
    function automatic bias_e first_bias(key_mode_e m, logic rowkey);
        case (m)
            MODE_BITKEY: first_bias = BIAS_UPPER;
            MODE_ROWKEY: first_bias = rowkey ? BIAS_UPPER : BIAS_LOWER;
            default:     first_bias = BIAS_SINGLE;
        endcase
    endfunction

endpackage

// File: rtl/rdr_seq.sv
module rdr_seq
    import rdr_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int GW     = 3,
    parameter int AW     = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_row,
    input  logic [1:0]      req_mode,
    input  logic            req_rowkey,
    output logic            accept,
    output logic            busy,
    output logic [AW-1:0]   rd_row,
    output logic [GW-1:0]   rd_grp,
    output bias_e           rd_bias,
    output key_mode_e       cur_mode,
    output logic            cap_ph1,
    output logic            cap_ph2,
    output logic            out_fire
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    rd_state_e     state;
    logic [GW-1:0] grp;
    logic [AW-1:0] row_q;
    key_mode_e     mode_q;
    logic          rowkey_q;

    assign accept = (state == ST_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            grp      <= '0;
            row_q    <= '0;
            mode_q   <= MODE_PLAIN;
            rowkey_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        row_q    <= req_row;
                        mode_q   <= key_mode_e'(req_mode);
                        rowkey_q <= req_rowkey;
                        grp      <= '0;
                        state    <= ST_PH1;
                    end
                end
                ST_PH1: begin
                    if (grp == LAST_GRP) begin
                        grp   <= '0;
                        state <= (mode_q == MODE_BITKEY) ? ST_PH2 : ST_OUT;
                    end else begin
                        grp <= grp + GW'(1);
                    end
                end
                ST_PH2: begin
                    if (grp == LAST_GRP) begin
                        grp   <= '0;
                        state <= ST_OUT;
                    end else begin
                        grp <= grp + GW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_PH1:  rd_bias = first_bias(mode_q, rowkey_q);
            ST_PH2:  rd_bias = BIAS_LOWER;
            default: rd_bias = BIAS_NONE;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign rd_row   = row_q;
    assign rd_grp   = grp;
    assign cur_mode = mode_q;
    assign cap_ph1  = (state == ST_PH1);
    assign cap_ph2  = (state == ST_PH2);
    assign out_fire = (state == ST_OUT);

endmodule

// File: rtl/rdr_capture.sv
module rdr_capture #(
    parameter int N_SA   = 16,
    parameter int GROUPS = 8,
    parameter int GW     = 3,
    parameter int ROW_W  = N_SA * GROUPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_ph1,
    input  logic             cap_ph2,
    input  logic [GW-1:0]    grp,
    input  logic [N_SA-1:0]  sa,
    output logic [ROW_W-1:0] row_ph1,
    output logic [ROW_W-1:0] row_ph2
);

    logic [N_SA-1:0] seg1 [GROUPS];
    logic [N_SA-1:0] seg2 [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                seg1[g] <= '0;
                seg2[g] <= '0;
            end else begin
                if (cap_ph1 && grp == GW'(g)) seg1[g] <= sa;
                if (cap_ph2 && grp == GW'(g)) seg2[g] <= sa;
            end
        end
        assign row_ph1[g*N_SA +: N_SA] = seg1[g];
        assign row_ph2[g*N_SA +: N_SA] = seg2[g];
    end

endmodule

// File: rtl/rdr_merge.sv
module rdr_merge
    import rdr_pkg::*;
#(
    parameter int ROW_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [ROW_W-1:0] req_key,
    input  key_mode_e        cur_mode,
    input  logic             out_fire,
    input  logic [ROW_W-1:0] row_ph1,
    input  logic [ROW_W-1:0] row_ph2,
    output logic [ROW_W-1:0] data_out,
    output logic             data_valid
);

    logic [ROW_W-1:0] key_q;
    logic [ROW_W-1:0] merged;

    always_comb begin
        if (cur_mode == MODE_BITKEY)
            merged = (key_q & row_ph1) | (~key_q & row_ph2);
        else
            merged = row_ph1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q      <= '0;
            data_out   <= '0;
            data_valid <= 1'b0;
        end else begin
            if (accept) key_q <= req_key;
            data_valid <= out_fire;
            if (out_fire) data_out <= merged;
        end
    end

endmodule

// File: rtl/rdr_decrypt_reader.sv
module rdr_decrypt_reader
    import rdr_pkg::*;
#(
    parameter int ROW_W = 128,
    parameter int N_SA  = 16,
    parameter int ROWS  = 8,
    localparam int GROUPS = ROW_W / N_SA,
    localparam int GW     = $clog2(GROUPS),
    localparam int AW     = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_row,
    input  logic [1:0]       req_mode,
    input  logic [ROW_W-1:0] req_key,
    input  logic             req_rowkey,
    output logic             busy,
    output logic [AW-1:0]    arr_row,
    output logic [GW-1:0]    arr_grp,
    output logic [1:0]       arr_bias,
    input  logic [N_SA-1:0]  sa_bits,
    output logic [ROW_W-1:0] data_out,
    output logic             data_valid
);

    logic             accept;
    bias_e            rd_bias;
    key_mode_e        cur_mode;
    logic             cap_ph1;
    logic             cap_ph2;
    logic             out_fire;
    logic [ROW_W-1:0] row_ph1;
    logic [ROW_W-1:0] row_ph2;

    rdr_seq #(.GROUPS(GROUPS), .GW(GW), .AW(AW)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_row    (req_row),
        .req_mode   (req_mode),
        .req_rowkey (req_rowkey),
        .accept     (accept),
        .busy       (busy),
        .rd_row     (arr_row),
        .rd_grp     (arr_grp),
        .rd_bias    (rd_bias),
        .cur_mode   (cur_mode),
        .cap_ph1    (cap_ph1),
        .cap_ph2    (cap_ph2),
        .out_fire   (out_fire)
    );

    assign arr_bias = rd_bias;

    rdr_capture #(.N_SA(N_SA), .GROUPS(GROUPS), .GW(GW), .ROW_W(ROW_W)) cap_i (
        .clk     (clk),
        .rst     (rst),
        .cap_ph1 (cap_ph1),
        .cap_ph2 (cap_ph2),
        .grp     (arr_grp),
        .sa      (sa_bits),
        .row_ph1 (row_ph1),
        .row_ph2 (row_ph2)
    );

    rdr_merge #(.ROW_W(ROW_W)) mrg_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_key    (req_key),
        .cur_mode   (cur_mode),
        .out_fire   (out_fire),
        .row_ph1    (row_ph1),
        .row_ph2    (row_ph2),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

endmodule

// File: rtl/rdr_decrypt_reader_chk.sv
module rdr_decrypt_reader_chk #(
    parameter int ROW_W = 128,
    parameter int N_SA  = 16,
    parameter int ROWS  = 8,
    localparam int GROUPS = ROW_W / N_SA,
    localparam int GW     = $clog2(GROUPS),
    localparam int AW     = $clog2(ROWS)
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic [AW-1:0] arr_row,
    input logic [GW-1:0] arr_grp,
    input logic [1:0]    arr_bias,
    input logic          data_valid
);

    localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

    assert_idle_no_bias_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> arr_bias == 2'd0);

    assert_row_held_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(arr_row)));

    assert_second_pass_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        (arr_bias == 2'd2 && $past(arr_bias) == 2'd1) |-> $past(arr_grp) == LAST_GRP);

    assert_group_steps_R7: assert property (@(posedge clk) disable iff (rst)
        (arr_bias != 2'd0 && arr_grp != LAST_GRP) |=> arr_grp == $past(arr_grp) + GW'(1));

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);

    assert_valid_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> !busy);

endmodule

bind rdr_decrypt_reader rdr_decrypt_reader_chk #(.ROW_W(ROW_W), .N_SA(N_SA), .ROWS(ROWS)) chk_i (.*);

// File: tb/rdr_decrypt_reader_tb_top.sv
module rdr_decrypt_reader_tb_top;

    localparam int ROW_W  = 128;
    localparam int N_SA   = 16;
    localparam int ROWS   = 8;
    localparam int GROUPS = ROW_W / N_SA;
    localparam int GW     = $clog2(GROUPS);
    localparam int AW     = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [AW-1:0]    req_row = '0;
    logic [1:0]       req_mode = 2'b00;
    logic [ROW_W-1:0] req_key = '0;
    logic             req_rowkey = 1'b0;
    logic             busy;
    logic [AW-1:0]    arr_row;
    logic [GW-1:0]    arr_grp;
    logic [1:0]       arr_bias;
    logic [N_SA-1:0]  sa_bits;
    logic [ROW_W-1:0] data_out;
    logic             data_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // Cell model: stored word per row; upper device conducts when the
    // stored bit is 0, lower (or single) device when it is 1.
    logic [ROW_W-1:0] store [ROWS];

    always #10 clk = ~clk;

    rdr_decrypt_reader #(.ROW_W(ROW_W), .N_SA(N_SA), .ROWS(ROWS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_row    (req_row),
        .req_mode   (req_mode),
        .req_key    (req_key),
        .req_rowkey (req_rowkey),
        .busy       (busy),
        .arr_row    (arr_row),
        .arr_grp    (arr_grp),
        .arr_bias   (arr_bias),
        .sa_bits    (sa_bits),
        .data_out   (data_out),
        .data_valid (data_valid)
    );

    always_comb begin
        sa_bits = '0;
        for (int i = 0; i < N_SA; i++) begin
            case (arr_bias)
                2'd1:    sa_bits[i] = ~store[arr_row][int'(arr_grp) * N_SA + i];
                2'd2:    sa_bits[i] =  store[arr_row][int'(arr_grp) * N_SA + i];
                2'd3:    sa_bits[i] =  store[arr_row][int'(arr_grp) * N_SA + i];
                default: sa_bits[i] = 1'b0;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input logic [ROW_W-1:0] act,
                         input logic [ROW_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One full read with a cycle-by-cycle reference of the port sequence.
    task automatic run_read(input int row, input logic [1:0] mode, input logic [ROW_W-1:0] key,
                            input logic rk, input logic [ROW_W-1:0] exp, input bit poke,
                            input string tag);
        int   nreads;
        logic [1:0] expb;
        @(negedge clk);
        check(busy == 1'b0, "R2 idle before request", ROW_W'(busy), '0);
        req_row = AW'(row); req_mode = mode; req_key = key; req_rowkey = rk; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nreads = (mode == 2'b10) ? 2 * GROUPS : GROUPS;
        for (int c = 0; c < nreads; c++) begin
            if (c > 0) @(negedge clk);
            if (mode == 2'b10)      expb = (c < GROUPS) ? 2'd1 : 2'd2;
            else if (mode == 2'b01) expb = rk ? 2'd1 : 2'd2;
            else                    expb = 2'd3;
            check(arr_bias == expb, {tag, " R3 bias pattern"}, ROW_W'(arr_bias), ROW_W'(expb));
            check(arr_grp == GW'(c % GROUPS), "R7 group order", ROW_W'(arr_grp), ROW_W'(c % GROUPS));
            check(arr_row == AW'(row) && busy, "R2 row held while busy", ROW_W'(arr_row), ROW_W'(row));
            check(!data_valid, "R9 no early valid", ROW_W'(data_valid), '0);
            if (poke && c == 3) begin
                req_valid = 1'b1; req_row = AW'(row ^ 1); req_mode = 2'b00;
            end
            if (poke && c == 4) req_valid = 1'b0;
        end
        @(negedge clk);
        check(arr_bias == 2'd0 && !data_valid, "R9 merge cycle", ROW_W'(arr_bias), '0);
        @(negedge clk);
        check(data_valid && !busy, "R9 valid strobe", ROW_W'(data_valid), 1);
        check(data_out == exp, {tag, " R8 R10 result"}, data_out, exp);
        @(negedge clk);
        check(!data_valid, "R9 single-cycle valid", ROW_W'(data_valid), '0);
        check(data_out == exp, "R9 result held", data_out, exp);
    endtask

    logic [ROW_W-1:0] pt0, tk0, kw, pt1, pt2, pt3, pt4, pt5;

    initial begin
        pt0 = {16{8'hAA}};
        tk0 = {4{32'h3C96_E10F}};
        kw  = {4{32'h5A17_C3E8}};
        pt1 = {4{32'hDEAD_BEEF}};
        pt2 = {4{32'h0123_4567}};
        pt3 = {4{32'hF00D_1234}};
        pt4 = {4{32'h89AB_CDEF}};
        pt5 = {4{32'h7654_3210}};
        store[0] = pt0 ^ tk0;
        store[1] = pt1 ^ {ROW_W{1'b1}};
        store[2] = pt2;
        store[3] = pt3;
        store[4] = ~pt4;
        store[5] = pt5;
        store[6] = '0;
        store[7] = '1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !data_valid && arr_bias == 2'd0 && data_out == '0,
              "R1 reset state", data_out, '0);

        run_read(0, 2'b10, tk0, 1'b0, pt0, 0, "R4 bitwise correct key");
        run_read(0, 2'b10, '0, 1'b0, pt0 ^ tk0, 0, "R10 all-zero key");
        run_read(0, 2'b10, kw, 1'b0, pt0 ^ tk0 ^ kw, 0, "R10 wrong key");
        run_read(4, 2'b10, '1, 1'b0, pt4, 0, "R8 all-ones key");
        run_read(5, 2'b10, '0, 1'b0, pt5, 0, "R8 all-zeros true key");
        run_read(1, 2'b01, kw, 1'b1, pt1, 0, "R5 row key 1");
        run_read(1, 2'b01, '1, 1'b0, ~pt1, 0, "R5 row key wrong");
        run_read(2, 2'b01, '0, 1'b0, pt2, 0, "R5 row key 0");
        run_read(3, 2'b00, kw, 1'b1, pt3, 0, "R6 plain");
        run_read(3, 2'b11, kw, 1'b0, pt3, 0, "R6 reserved as plain");
        run_read(0, 2'b10, tk0, 1'b0, pt0, 1, "R2 request while busy");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule